// File: doc/BRIEF.md
# Linear Burst Bus Master Sequencer

This block runs a series of 32-bit memory transfers, all reads or all writes, inside one bus tenure that has already been granted. A request carries a direction, an access kind, a start address and a beat count. The sequencer then presents one address per beat, and the address rises by four bytes on each beat. A beat ends when the bus-ready input is sampled high in the data phase.

When linear bursting is allowed for the request, only the first beat has an address cycle with the address strobe. Every later beat moves straight from one data phase to the next. The address bus still carries the correct address on every beat. Reads and writes have separate burst enables. An external permission pin can veto read bursting, and it has no effect on writes. Descriptor and initialization accesses always give each beat its own address cycle.

The request port uses a valid/ready handshake. `req_ready` is high only while the sequencer is idle. A request is taken on a clock edge where `req_valid` and `req_ready` are both high, and all request fields and enable inputs are captured on that edge. While a tenure is running, `req_ready` is low, so a waiting requester must hold its request until the sequencer is idle again. The bus side has no back-pressure beyond `bus_ready`, which holds the current beat.

Top module: `lburst_seq`

## Requirements
- R1: While reset is held and in the first cycle after it, `req_ready` is 1 and `addr_strobe`, `data_act` and `done` are 0.
- R2: In the cycle after a request is accepted, `addr_strobe` is 1 for exactly one cycle, `bus_addr` equals the start address and `bus_wr` equals the requested direction (1 = write). The data phase (`data_act` = 1) follows in the next cycle.
- R3: In the data phase, a beat ends only on a clock edge where `bus_ready` is 1. Until then `data_act` stays 1 and `bus_addr` is held.
- R4: Each completed beat that is not the last one raises `bus_addr` by 4, modulo 2^32.
- R5: With bursting in effect, every beat after the first is data-only. `data_act` stays 1 in the cycle after a non-final beat ends, and `addr_strobe` stays 0.
- R6: Without bursting, each beat after the first starts with its own one-cycle address cycle (`addr_strobe` = 1, `data_act` = 0) that shows the new address.
- R7: A read bursts only when `rd_burst_en` = 1 and `rd_burst_pin` = 1. A write bursts when `wr_burst_en` = 1, whatever the level of `rd_burst_pin`.
- R8: The kind field encodes 0 = data, 1 = descriptor, 2 = initialization and 3 = reserved. Only kind 0 may burst. All other kinds behave as in R6, whatever the enables are.
- R9: In the cycle after the last beat ends, `done` is 1 for exactly one cycle and `req_ready` is 1. The next request starts a new tenure with an address cycle. A beat count of 0 is treated as 1.
- R10: During a tenure, `req_ready` is 0. Changes on `req_valid`, on any request field or on the burst enable inputs have no effect on that tenure.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Sequencer idle and able to take a request |
| req_write | input | 1 | 1 = write tenure, 0 = read tenure |
| req_kind | input | 2 | 0 data, 1 descriptor, 2 initialization, 3 reserved |
| req_addr | input | 32 | Start byte address |
| req_beats | input | 8 | Number of beats (0 counts as 1) |
| rd_burst_en | input | 1 | Allow bursting on reads |
| wr_burst_en | input | 1 | Allow bursting on writes |
| rd_burst_pin | input | 1 | External permission for read bursting (0 vetoes) |
| bus_ready | input | 1 | Current data beat completes when high |
| bus_addr | output | 32 | Address of the current beat |
| addr_strobe | output | 1 | Address cycle marker |
| bus_wr | output | 1 | Direction of the current tenure |
| data_act | output | 1 | Data phase in progress |
| done | output | 1 | One-cycle pulse after the final beat |

## Verification
The bench targets tenures whose `bus_ready` stalls in random places. A sequencer that closed a beat without seeing ready would skip addresses or end too early. Descriptor, initialization and reserved kinds are run with every enable set, and reads are run with the permission pin low. Together these catch a design that bursts when it must re-strobe, which shows up as a missing `addr_strobe` cycle. Start addresses near the top of the address space check wrap-around of the increment. A beat count of zero checks that exactly one beat is run. The enables and request fields are changed at random during each tenure, which exposes a design that reads them live instead of capturing them at acceptance.

// File: rtl/lburst_pkg.sv
package lburst_pkg;
  typedef enum logic [1:0] {
    K_DATA = 2'd0,
    K_DESC = 2'd1,
    K_INIT = 2'd2,
    K_RSVD = 2'd3
  } xfer_kind_e;

  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_ADDR = 2'd1,
    S_DATA = 2'd2
  } seq_state_e;
endpackage

// File: rtl/lburst_policy.sv
module lburst_policy
  import lburst_pkg::*;
(
  input  xfer_kind_e kind,
  input  logic       write,
  input  logic       rd_en,
  input  logic       wr_en,
  input  logic       rd_pin,
  output logic       burst_ok
);
  logic dir_ok;

  always_comb begin
    if (write) dir_ok = wr_en;
    else       dir_ok = rd_en & rd_pin;
    burst_ok = (kind == K_DATA) & dir_ok;
  end
endmodule

// File: rtl/lburst_addr_ctr.sv
module lburst_addr_ctr #(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] start_addr,
  input  logic [CW-1:0] beats_in,
  input  logic          advance,
  output logic [AW-1:0] addr,
  output logic          last
);
  localparam logic [AW-1:0] STEP = AW'(DW / 8);

  logic [CW-1:0] remain;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr   <= '0;
      remain <= '0;
    end else if (load) begin
      addr   <= start_addr;
      remain <= (beats_in == '0) ? '0 : beats_in - CW'(1);
    end else if (advance) begin
      addr   <= addr + STEP;
      remain <= remain - CW'(1);
    end
  end

  assign last = (remain == '0);

  // R4
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    advance && !load |=> addr == $past(addr) + STEP);

  // R3
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !advance && !load |=> $stable(addr));
endmodule

// File: rtl/lburst_fsm.sv
module lburst_fsm
  import lburst_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  input  logic write_in,
  input  logic burst_in,
  input  logic last,
  input  logic bus_ready,
  output logic req_ready,
  output logic load,
  output logic advance,
  output logic addr_strobe,
  output logic data_act,
  output logic bus_wr,
  output logic done
);
  seq_state_e state, nstate;
  logic burst_q, wr_q, done_q;
  logic beat_end;

  assign req_ready   = (state == S_IDLE);
  assign load        = req_valid & req_ready;
  assign beat_end    = (state == S_DATA) & bus_ready;
  assign advance     = beat_end & ~last;
  assign addr_strobe = (state == S_ADDR);
  assign data_act    = (state == S_DATA);
  assign bus_wr      = wr_q & ~req_ready;
  assign done        = done_q;

  always_comb begin
    nstate = state;
    unique case (state)
      S_IDLE: if (load) nstate = S_ADDR;
      S_ADDR: nstate = S_DATA;
      S_DATA: begin
        if (beat_end) begin
          if (last)         nstate = S_IDLE;
          else if (burst_q) nstate = S_DATA;
          else              nstate = S_ADDR;
        end
      end
      default: nstate = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      burst_q <= 1'b0;
      wr_q    <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state  <= nstate;
      done_q <= beat_end & last;
      if (load) begin
        burst_q <= burst_in;
        wr_q    <= write_in;
      end
    end
  end

  // R2
  strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    addr_strobe |=> !addr_strobe && data_act);

  // R5
  burst_chain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    advance && burst_q |=> data_act && !addr_strobe);

  // R6
  readdr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    advance && !burst_q |=> addr_strobe && !data_act);

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    beat_end && last |=> done && req_ready);

  // R3
  wait_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    data_act && !bus_ready |=> data_act);
endmodule

// File: rtl/lburst_seq.sv
module lburst_seq
  import lburst_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [1:0]    req_kind,
  input  logic [AW-1:0] req_addr,
  input  logic [CW-1:0] req_beats,
  input  logic          rd_burst_en,
  input  logic          wr_burst_en,
  input  logic          rd_burst_pin,
  input  logic          bus_ready,
  output logic [AW-1:0] bus_addr,
  output logic          addr_strobe,
  output logic          bus_wr,
  output logic          data_act,
  output logic          done
);
  xfer_kind_e kind;
  logic burst_sel, load, advance, last;

  assign kind = xfer_kind_e'(req_kind);

  lburst_policy u_policy (
    .kind     (kind),
    .write    (req_write),
    .rd_en    (rd_burst_en),
    .wr_en    (wr_burst_en),
    .rd_pin   (rd_burst_pin),
    .burst_ok (burst_sel)
  );

  lburst_addr_ctr #(.AW(AW), .DW(DW), .CW(CW)) u_ctr (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (load),
    .start_addr (req_addr),
    .beats_in   (req_beats),
    .advance    (advance),
    .addr       (bus_addr),
    .last       (last)
  );

  lburst_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .write_in    (req_write),
    .burst_in    (burst_sel),
    .last        (last),
    .bus_ready   (bus_ready),
    .req_ready   (req_ready),
    .load        (load),
    .advance     (advance),
    .addr_strobe (addr_strobe),
    .data_act    (data_act),
    .bus_wr      (bus_wr),
    .done        (done)
  );

  // R8
  kind_no_burst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load && kind != K_DATA |-> !burst_sel);

  // R7
  pin_veto_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load && !req_write && !rd_burst_pin |-> !burst_sel);

  // R2
  accept_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> addr_strobe && bus_addr == $past(req_addr) && bus_wr == $past(req_write));

  // R10
  busy_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_strobe || data_act) |-> !req_ready);
endmodule

// File: tb/lburst_seq_tb.sv
module lburst_seq_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_ready, req_write;
  logic [1:0]  req_kind;
  logic [31:0] req_addr;
  logic [7:0]  req_beats;
  logic        rd_burst_en, wr_burst_en, rd_burst_pin, bus_ready;
  logic [31:0] bus_addr;
  logic        addr_strobe, bus_wr, data_act, done;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  lburst_seq u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_kind(req_kind), .req_addr(req_addr),
    .req_beats(req_beats), .rd_burst_en(rd_burst_en), .wr_burst_en(wr_burst_en),
    .rd_burst_pin(rd_burst_pin), .bus_ready(bus_ready), .bus_addr(bus_addr),
    .addr_strobe(addr_strobe), .bus_wr(bus_wr), .data_act(data_act), .done(done)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit exp_burst(input bit w, input logic [1:0] k,
                                   input bit rde, input bit wre, input bit pin);
    if (k != 2'd0) return 1'b0;
    return w ? wre : (rde && pin);
  endfunction

  task automatic run_txn(input bit w, input logic [1:0] k, input logic [31:0] a,
                         input logic [7:0] n, input bit rde, input bit wre,
                         input bit pin, input int rdy_pct);
    bit burst;
    int total, beat, phase;
    logic [31:0] ea;
    bit rdy, fin, waited;
    string ptag;
    burst = exp_burst(w, k, rde, wre, pin);
    total = (n == 8'd0) ? 1 : int'(n);
    if (k != 2'd0) ptag = "R8";
    else if (!w && rde && !pin) ptag = "R7";
    else if (burst) ptag = "R5";
    else ptag = "R6";
    req_valid = 1'b1; req_write = w; req_kind = k; req_addr = a; req_beats = n;
    rd_burst_en = rde; wr_burst_en = wre; rd_burst_pin = pin; bus_ready = 1'b0;
    @(posedge clk); @(negedge clk);
    ea = a; beat = 1; phase = 1; fin = 1'b0; waited = 1'b0;
    while (!fin) begin
      if (beat == 1) begin
        chk("R2 strobe", addr_strobe, (phase == 1));
        chk("R2 data_act", data_act, (phase == 2));
      end else if (waited) begin
        chk("R3 hold data", data_act, 1'b1);
      end else begin
        chk({ptag, " strobe"}, addr_strobe, (phase == 1));
        chk({ptag, " data_act"}, data_act, (phase == 2));
      end
      chk(beat == 1 ? "R2 addr" : "R4 addr", bus_addr, ea);
      chk("R2 bus_wr", bus_wr, w);
      chk("R10 req_ready", req_ready, 1'b0);
      chk("R9 no early done", done, 1'b0);
      req_valid = 1'($urandom); req_write = 1'($urandom); req_kind = 2'($urandom);
      req_addr = $urandom; req_beats = 8'($urandom);
      rd_burst_en = 1'($urandom); wr_burst_en = 1'($urandom); rd_burst_pin = 1'($urandom);
      rdy = (($urandom % 100) < rdy_pct);
      bus_ready = rdy;
      @(posedge clk);
      waited = 1'b0;
      if (phase == 1) phase = 2;
      else if (rdy) begin
        if (beat == total) fin = 1'b1;
        else begin
          ea = ea + 32'd4; beat++;
          if (!burst) phase = 1;
        end
      end else waited = 1'b1;
      @(negedge clk);
    end
    req_valid = 1'b0; bus_ready = 1'b0;
    chk("R9 done", done, 1'b1);
    chk("R9 req_ready", req_ready, 1'b1);
    chk("R9 idle strobe", addr_strobe, 1'b0);
    chk("R9 idle data", data_act, 1'b0);
    @(posedge clk); @(negedge clk);
    chk("R9 done single", done, 1'b0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_kind = 2'd0;
    req_addr = '0; req_beats = '0; rd_burst_en = 1'b0; wr_burst_en = 1'b0;
    rd_burst_pin = 1'b0; bus_ready = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 ready in reset", req_ready, 1'b1);
    chk("R1 strobe in reset", addr_strobe, 1'b0);
    rst_n = 1'b1;
    @(posedge clk); @(negedge clk);
    chk("R1 ready", req_ready, 1'b1);
    chk("R1 strobe", addr_strobe, 1'b0);
    chk("R1 data_act", data_act, 1'b0);
    chk("R1 done", done, 1'b0);

    run_txn(1'b0, 2'd0, 32'h0000_1000, 8'd4, 1'b1, 1'b0, 1'b1, 100); // R5 read burst
    run_txn(1'b1, 2'd0, 32'h0000_2000, 8'd4, 1'b0, 1'b1, 1'b0, 100); // R7 write ignores pin
    run_txn(1'b0, 2'd0, 32'h0000_3000, 8'd3, 1'b1, 1'b1, 1'b0, 100); // R7 pin veto
    run_txn(1'b0, 2'd1, 32'h0000_4000, 8'd3, 1'b1, 1'b1, 1'b1, 100); // R8 descriptor
    run_txn(1'b1, 2'd2, 32'h0000_5000, 8'd3, 1'b1, 1'b1, 1'b1, 100); // R8 init
    run_txn(1'b1, 2'd3, 32'h0000_6000, 8'd2, 1'b1, 1'b1, 1'b1, 50);  // R8 reserved
    run_txn(1'b1, 2'd0, 32'h0000_7000, 8'd3, 1'b0, 1'b0, 1'b1, 100); // R6 no enable
    run_txn(1'b0, 2'd0, 32'h0000_8000, 8'd0, 1'b1, 1'b1, 1'b1, 100); // R9 zero beats
    run_txn(1'b1, 2'd0, 32'hFFFF_FFF8, 8'd4, 1'b1, 1'b1, 1'b1, 40);  // R4 wrap
    run_txn(1'b0, 2'd0, 32'hFFFF_FFFC, 8'd3, 1'b0, 1'b0, 1'b0, 40);  // R4 wrap, R6

    for (int i = 0; i < 60; i++) begin
      run_txn(1'($urandom), 2'($urandom), $urandom & 32'hFFFF_FFFC,
              8'($urandom % 9), 1'($urandom), 1'($urandom), 1'($urandom),
              30 + int'($urandom % 71));
    end

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule